// File: doc/BRIEF.md
# Early-Termination Block-Matching Motion Estimator

This block finds the integer-pixel motion vector for one macro block. A square template of `TPL_LEN` x `TPL_LEN` pixels is compared against every candidate block inside a square search window of `WIN_LEN` x `WIN_LEN` pixels. Candidate offsets run from `-RANGE` to `+RANGE` on both axes, and the window must satisfy `WIN_LEN = TPL_LEN + 2*RANGE`. Both pixel stores are external synchronous memories. The block drives one read enable and two addresses, and the data comes back on the following cycle.

The matching cost is the sum of absolute differences (SAD) over co-located pixels. Each candidate's cost is built up one template row at a time. After every completed row the running sum is compared with the best cost found so far. Once the running sum is no longer smaller, the candidate is dropped and its remaining rows are never fetched. With a good early match, most candidates therefore cost one row of reads instead of a full block.

A one-cycle `start` pulse launches the search. When all candidates have been handled, `done` pulses for one cycle, and the signed vector and its cost are presented and held.

Top module: `me_block_match`

## Requirements
- R1: After reset, `done` and `rd_en` are low, `min_sad` is all ones (the largest `ERR_W`-bit value) and both vector components are zero.
- R2: `min_sad` equals the sum over all template pixels of |template − window| for the reported candidate, and no candidate has a smaller sum.
- R3: For candidate offset (dy, dx), template pixel (r, c) is read at `tpl_addr = r*TPL_LEN + c` together with window pixel `win_addr = (RANGE+dy+r)*WIN_LEN + (RANGE+dx+c)`. Read data is taken on the cycle after `rd_en`. The reported `mv_y`/`mv_x` are dy/dx in two's complement.
- R4: Every offset from −RANGE to +RANGE on both axes is evaluated, including all four corners.
- R5: Candidates are visited with dy in the outer loop and dx in the inner loop, both ascending from −RANGE. A later candidate with an equal cost never displaces the earlier one.
- R6: The first candidate always runs all rows. Every candidate is checked after each full row of `TPL_LEN` reads and abandoned as soon as its partial sum is greater than or equal to the best cost. The number of read cycles for a search therefore equals `TPL_LEN` times the number of rows actually evaluated.
- R7: `done` is high for exactly one cycle. `mv_x`, `mv_y` and `min_sad` stay unchanged after it until the next accepted `start`.
- R8: A `start` pulse that arrives while a search is in progress is ignored and does not alter the result or the number of reads.
- R9: Each evaluated row costs `TPL_LEN + 2` cycles. `done` rises on the clock edge `rows*(TPL_LEN+2)` edges after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle pulse that starts a search |
| rd_en | output | 1 | Read strobe for both memories |
| tpl_addr | output | $clog2(TPL_LEN*TPL_LEN) | Template pixel address, row-major |
| tpl_data | input | PIX_W | Template pixel returned one cycle after `rd_en` |
| win_addr | output | $clog2(WIN_LEN*WIN_LEN) | Search-window pixel address, row-major |
| win_data | input | PIX_W | Window pixel returned one cycle after `rd_en` |
| done | output | 1 | One-cycle completion pulse |
| mv_x | output | $clog2(2*RANGE+1)+1 | Signed horizontal displacement of the best match |
| mv_y | output | $clog2(2*RANGE+1)+1 | Signed vertical displacement of the best match |
| min_sad | output | ERR_W | Cost of the best match |

## Verification
The embedded properties assume three things. Both memories return data exactly one cycle after an address is presented with `rd_en`. `ERR_W` is wide enough that a full-block sum never wraps, which is why the accumulator may be checked as non-decreasing between clears. `start` pulses that land mid-search are the only kind of interference expected. The bench models both memories as registered arrays that answer one cycle after `rd_en`. It uses a 4x4 template with a ±4 range, so the largest sum stays far below the 16-bit limit. It injects `start` pulses only at chosen points inside a running search.

// File: rtl/me_pkg.sv
`timescale 1ns/1ps
package me_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_DRAIN = 3'd2,
    ST_CHECK = 3'd3,
    ST_FIN   = 3'd4
  } me_state_e;
endpackage

// File: rtl/me_addr_gen.sv
`timescale 1ns/1ps
module me_addr_gen #(
  parameter int TPL_LEN = 16,
  parameter int WIN_LEN = 64,
  parameter int RCW     = 4,
  parameter int CW      = 6,
  parameter int TA_W    = 8,
  parameter int WA_W    = 12
) (
  input  logic [RCW-1:0]  row,
  input  logic [RCW-1:0]  col,
  input  logic [CW-1:0]   cy,
  input  logic [CW-1:0]   cx,
  output logic [TA_W-1:0] tpl_addr,
  output logic [WA_W-1:0] win_addr
);
  // Template is read row-major; window origin shifts by the candidate index.
  always_comb begin
    tpl_addr = TA_W'(row) * TA_W'(TPL_LEN) + TA_W'(col);
    win_addr = (WA_W'(cy) + WA_W'(row)) * WA_W'(WIN_LEN) + WA_W'(cx) + WA_W'(col);
  end
endmodule

// File: rtl/me_sad_acc.sv
`timescale 1ns/1ps
module me_sad_acc #(
  parameter int PIX_W = 8,
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             clr,
  input  logic [PIX_W-1:0] tpl_data,
  input  logic [PIX_W-1:0] win_data,
  output logic [ERR_W-1:0] acc
);
  logic             vld_q;
  logic [PIX_W-1:0] diff;
  logic [ERR_W-1:0] acc_q, acc_d;

  // Memory data is valid one cycle after the read strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= rd_en;
  end

  always_comb begin
    diff = (tpl_data > win_data) ? (tpl_data - win_data) : (win_data - tpl_data);
    if (clr)        acc_d = '0;
    else if (vld_q) acc_d = acc_q + ERR_W'(diff);
    else            acc_d = acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (acc_q >= $past(acc_q))); // R2
endmodule

// File: rtl/me_best_reg.sv
`timescale 1ns/1ps
module me_best_reg #(
  parameter int ERR_W = 16,
  parameter int CW    = 6,
  parameter int RANGE = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init,
  input  logic                upd,
  input  logic [ERR_W-1:0]    err_in,
  input  logic [CW-1:0]       cy,
  input  logic [CW-1:0]       cx,
  output logic [ERR_W-1:0]    best_err,
  output logic signed [CW:0]  mv_x,
  output logic signed [CW:0]  mv_y
);
  localparam int MW = CW + 1;

  logic [ERR_W-1:0]    err_q, err_d;
  logic signed [MW-1:0] mx_q, mx_d, my_q, my_d;

  always_comb begin
    err_d = err_q;
    mx_d  = mx_q;
    my_d  = my_q;
    if (init) begin
      err_d = '1;
      mx_d  = '0;
      my_d  = '0;
    end else if (upd) begin
      err_d = err_in;
      mx_d  = $signed({1'b0, cx}) - $signed(MW'(RANGE));
      my_d  = $signed({1'b0, cy}) - $signed(MW'(RANGE));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '1;
      mx_q  <= '0;
      my_q  <= '0;
    end else begin
      err_q <= err_d;
      mx_q  <= mx_d;
      my_q  <= my_d;
    end
  end

  assign best_err = err_q;
  assign mv_x     = mx_q;
  assign mv_y     = my_q;

  AST_BEST_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(init) |-> (err_q <= $past(err_q))); // R5
  AST_MV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mx_q >= -RANGE) && (mx_q <= RANGE) && (my_q >= -RANGE) && (my_q <= RANGE)); // R4
endmodule

// File: rtl/me_scan_ctrl.sv
`timescale 1ns/1ps
module me_scan_ctrl
  import me_pkg::*;
#(
  parameter int TPL_LEN = 16,
  parameter int RANGE   = 24,
  parameter int ERR_W   = 16,
  parameter int RCW     = 4,
  parameter int CW      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ERR_W-1:0] acc,
  input  logic [ERR_W-1:0] best_err,
  output logic             rd_en,
  output logic [RCW-1:0]   row,
  output logic [RCW-1:0]   col,
  output logic [CW-1:0]    cy,
  output logic [CW-1:0]    cx,
  output logic             acc_clr,
  output logic             best_init,
  output logic             best_upd,
  output logic             done
);
  localparam logic [RCW-1:0] RC_LAST = RCW'(TPL_LEN - 1);
  localparam logic [CW-1:0]  C_LAST  = CW'(2 * RANGE);

  me_state_e      st_q, st_d;
  logic [RCW-1:0] row_q, row_d, col_q, col_d;
  logic [CW-1:0]  cy_q, cy_d, cx_q, cx_d;
  logic           beats;

  always_comb begin
    st_d      = st_q;
    row_d     = row_q;
    col_d     = col_q;
    cy_d      = cy_q;
    cx_d      = cx_q;
    acc_clr   = 1'b0;
    best_init = 1'b0;
    best_upd  = 1'b0;
    beats     = acc < best_err;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          best_init = 1'b1;
          acc_clr   = 1'b1;
          row_d     = '0;
          col_d     = '0;
          cy_d      = '0;
          cx_d      = '0;
          st_d      = ST_RUN;
        end
      end
      ST_RUN: begin
        if (col_q == RC_LAST) st_d = ST_DRAIN;
        else                  col_d = col_q + 1'b1;
      end
      ST_DRAIN: st_d = ST_CHECK;
      ST_CHECK: begin
        if (beats && (row_q != RC_LAST)) begin
          row_d = row_q + 1'b1;
          col_d = '0;
          st_d  = ST_RUN;
        end else begin
          // Candidate finished or broken off: move to the next offset.
          best_upd = beats;
          acc_clr  = 1'b1;
          row_d    = '0;
          col_d    = '0;
          if (cx_q == C_LAST) begin
            cx_d = '0;
            if (cy_q == C_LAST) begin
              st_d = ST_FIN;
            end else begin
              cy_d = cy_q + 1'b1;
              st_d = ST_RUN;
            end
          end else begin
            cx_d = cx_q + 1'b1;
            st_d = ST_RUN;
          end
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      row_q <= '0;
      col_q <= '0;
      cy_q  <= '0;
      cx_q  <= '0;
    end else begin
      st_q  <= st_d;
      row_q <= row_d;
      col_q <= col_d;
      cy_q  <= cy_d;
      cx_q  <= cx_d;
    end
  end

  assign rd_en = (st_q == ST_RUN);
  assign done  = (st_q == ST_FIN);
  assign row   = row_q;
  assign col   = col_q;
  assign cy    = cy_q;
  assign cx    = cx_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_BREAK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_CHECK) && (acc >= best_err)) |=> ((row_q == '0) && (st_q != ST_DRAIN))); // R6
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_RUN) && start) |=> ((cy_q == $past(cy_q)) && (cx_q == $past(cx_q)))); // R8
endmodule

// File: rtl/me_block_match.sv
`timescale 1ns/1ps
module me_block_match #(
  parameter int TPL_LEN = 16,
  parameter int WIN_LEN = 64,
  parameter int RANGE   = 24,
  parameter int PIX_W   = 8,
  parameter int ERR_W   = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  output logic                                   rd_en,
  output logic [$clog2(TPL_LEN*TPL_LEN)-1:0]     tpl_addr,
  input  logic [PIX_W-1:0]                       tpl_data,
  output logic [$clog2(WIN_LEN*WIN_LEN)-1:0]     win_addr,
  input  logic [PIX_W-1:0]                       win_data,
  output logic                                   done,
  output logic signed [$clog2(2*RANGE+1):0]      mv_x,
  output logic signed [$clog2(2*RANGE+1):0]      mv_y,
  output logic [ERR_W-1:0]                       min_sad
);
  localparam int RCW  = $clog2(TPL_LEN);
  localparam int CW   = $clog2(2 * RANGE + 1);
  localparam int TA_W = $clog2(TPL_LEN * TPL_LEN);
  localparam int WA_W = $clog2(WIN_LEN * WIN_LEN);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [RCW-1:0]   row, col;
  logic [CW-1:0]    cy, cx;
  logic [ERR_W-1:0] acc, best_err;
  logic             acc_clr, best_init, best_upd;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  me_scan_ctrl #(
    .TPL_LEN(TPL_LEN), .RANGE(RANGE), .ERR_W(ERR_W), .RCW(RCW), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start(start), .acc(acc), .best_err(best_err),
    .rd_en(rd_en), .row(row), .col(col), .cy(cy), .cx(cx),
    .acc_clr(acc_clr), .best_init(best_init), .best_upd(best_upd), .done(done)
  );

  me_addr_gen #(
    .TPL_LEN(TPL_LEN), .WIN_LEN(WIN_LEN), .RCW(RCW), .CW(CW), .TA_W(TA_W), .WA_W(WA_W)
  ) u_addr (
    .row(row), .col(col), .cy(cy), .cx(cx), .tpl_addr(tpl_addr), .win_addr(win_addr)
  );

  me_sad_acc #(
    .PIX_W(PIX_W), .ERR_W(ERR_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_int_n), .rd_en(rd_en), .clr(acc_clr),
    .tpl_data(tpl_data), .win_data(win_data), .acc(acc)
  );

  me_best_reg #(
    .ERR_W(ERR_W), .CW(CW), .RANGE(RANGE)
  ) u_best (
    .clk(clk), .rst_n(rst_int_n), .init(best_init), .upd(best_upd), .err_in(acc),
    .cy(cy), .cx(cx), .best_err(best_err), .mv_x(mv_x), .mv_y(mv_y)
  );

  assign min_sad = best_err;

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(done) && !start) |-> ($stable(min_sad) && $stable(mv_x) && $stable(mv_y))); // R7
endmodule

// File: tb/test_me_block_match.sv
`timescale 1ns/1ps
module test_me_block_match;
  localparam int L    = 4;
  localparam int W    = 12;
  localparam int R    = 4;
  localparam int PW   = 8;
  localparam int EW   = 16;
  localparam int TA_W = $clog2(L*L);
  localparam int WA_W = $clog2(W*W);
  localparam int MVW  = $clog2(2*R+1) + 1;
  localparam int EMAX = (1 << EW) - 1;

  logic clk = 1'b0;
  logic rst_n, start;
  logic rd_en, done;
  logic [TA_W-1:0] tpl_addr;
  logic [WA_W-1:0] win_addr;
  logic [PW-1:0]   tpl_q, win_q;
  logic signed [MVW-1:0] mv_x, mv_y;
  logic [EW-1:0]   min_sad;

  logic [PW-1:0] tpl_m [L*L];
  logic [PW-1:0] win_m [W*W];
  int rd_cnt = 0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  me_block_match #(.TPL_LEN(L), .WIN_LEN(W), .RANGE(R), .PIX_W(PW), .ERR_W(EW)) i_me_block_match (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en),
    .tpl_addr(tpl_addr), .tpl_data(tpl_q), .win_addr(win_addr), .win_data(win_q),
    .done(done), .mv_x(mv_x), .mv_y(mv_y), .min_sad(min_sad)
  );

  // Registered memory models: data one cycle after the strobe.
  always @(posedge clk) begin
    if (rd_en) begin
      tpl_q  <= tpl_m[tpl_addr];
      win_q  <= win_m[win_addr];
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic fill_window(input int seed);
    for (int y = 0; y < W; y++)
      for (int x = 0; x < W; x++)
        win_m[y*W+x] = PW'((x*37 + y*91 + seed*13 + x*y*7 + (x^y)*5) & 255);
  endtask

  task automatic copy_tpl(input int dy, input int dx);
    for (int r = 0; r < L; r++)
      for (int c = 0; c < L; c++)
        tpl_m[r*L+c] = win_m[(R+dy+r)*W + R+dx+c];
  endtask

  // Reference: raster scan, row-wise break-off, strict improvement only.
  task automatic model(output int ex, output int ey, output int es, output int er);
    int best;
    best = EMAX; ex = 0; ey = 0; er = 0;
    for (int cy = 0; cy <= 2*R; cy++)
      for (int cx = 0; cx <= 2*R; cx++) begin
        int acc;
        acc = 0;
        for (int r = 0; r < L; r++) begin
          for (int c = 0; c < L; c++) begin
            int d;
            d = int'(tpl_m[r*L+c]) - int'(win_m[(cy+r)*W + cx+c]);
            acc += (d < 0) ? -d : d;
          end
          er += L;
          if (acc >= best) break;
          if (r == L-1) begin
            best = acc; ey = cy - R; ex = cx - R;
          end
        end
      end
    es = best;
  endtask

  task automatic run_search(input bit extra, output int lat, output int ax, output int ay,
                            output int as, output int ar);
    int r0;
    r0 = rd_cnt;
    @(negedge clk); start = 1'b1;
    @(posedge clk); lat = 0;
    @(negedge clk); start = 1'b0;
    while (!done && lat < 100000) begin
      @(posedge clk); lat++;
      @(negedge clk);
      start = extra && (lat == 7 || lat == 40);
    end
    start = 1'b0;
    ax = int'(mv_x); ay = int'(mv_y); as = int'(min_sad); ar = rd_cnt - r0;
  endtask

  task automatic verify(input bit extra, output int ax, output int ay);
    int ex, ey, es, er, lat, as, ar;
    model(ex, ey, es, er);
    run_search(extra, lat, ax, ay, as, ar);
    check("R3", "mv_x", ax, ex);
    check("R3", "mv_y", ay, ey);
    check("R2", "min_sad", as, es);
    check("R6", "read cycles", ar, er);
    check("R9", "latency edges", lat, (er / L) * (L + 2));
  endtask

  task automatic test_reset;
    check("R1", "done", int'(done), 0);
    check("R1", "rd_en", int'(rd_en), 0);
    check("R1", "min_sad", int'(min_sad), EMAX);
    check("R1", "mv_x", int'(mv_x), 0);
    check("R1", "mv_y", int'(mv_y), 0);
  endtask

  task automatic test_exact_match;
    int ax, ay;
    fill_window(1); copy_tpl(1, -2);
    verify(1'b0, ax, ay);
    check("R2", "exact mv_x", ax, -2);
    check("R2", "exact mv_y", ay, 1);
    check("R2", "exact sad", int'(min_sad), 0);
  endtask

  task automatic test_noisy;
    int ax, ay;
    fill_window(2); copy_tpl(-3, 2);
    tpl_m[5] = tpl_m[5] ^ 8'h15;
    tpl_m[10] = tpl_m[10] ^ 8'h03;
    verify(1'b0, ax, ay);
  endtask

  task automatic test_corners;
    int ax, ay;
    fill_window(3); copy_tpl(-R, -R);
    verify(1'b0, ax, ay);
    check("R4", "corner low x", ax, -R);
    check("R4", "corner low y", ay, -R);
    fill_window(4); copy_tpl(R, R);
    verify(1'b0, ax, ay);
    check("R4", "corner high x", ax, R);
    check("R4", "corner high y", ay, R);
  endtask

  task automatic test_tie;
    int ax, ay;
    for (int i = 0; i < W*W; i++) win_m[i] = 8'd10;
    for (int i = 0; i < L*L; i++) tpl_m[i] = 8'd0;
    verify(1'b0, ax, ay);
    check("R5", "tie mv_x first", ax, -R);
    check("R5", "tie mv_y first", ay, -R);
    check("R5", "tie sad", int'(min_sad), 10*L*L);
  endtask

  task automatic test_done_hold;
    int ax, ay, s0;
    fill_window(5); copy_tpl(2, 3);
    verify(1'b0, ax, ay);
    s0 = int'(min_sad);
    @(negedge clk);
    check("R7", "done after one cycle", int'(done), 0);
    repeat (4) @(negedge clk);
    check("R7", "mv_x held", int'(mv_x), ax);
    check("R7", "mv_y held", int'(mv_y), ay);
    check("R7", "sad held", int'(min_sad), s0);
  endtask

  task automatic test_busy_start;
    int ax, ay;
    fill_window(6); copy_tpl(0, -1);
    verify(1'b1, ax, ay);
    check("R8", "ignored start mv_x", ax, -1);
    check("R8", "ignored start mv_y", ay, 0);
    repeat (3) @(negedge clk);
    check("R8", "no second search", int'(rd_en), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual no done expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    start = 1'b0;
    rst_n = 1'b0;
    for (int i = 0; i < L*L; i++) tpl_m[i] = '0;
    for (int i = 0; i < W*W; i++) win_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_exact_match();
    test_noisy();
    test_corners();
    test_tie();
    test_done_hold();
    test_busy_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule